// File: doc/BRIEF.md
# Banked Multi-Lane Scratchpad with Conflict Replay

This block is a word-addressed on-chip scratchpad that serves a whole vector of lanes in one request. Each lane has an enable bit and a byte address. A request-wide flag selects a read of every enabled lane or a write from every enabled lane. The storage is cut into independent word-wide banks, and each bank can supply or accept one word per cycle. Consecutive words fall in consecutive banks, so unit-stride and other well-spread patterns finish in a single cycle.

When several enabled lanes map to the same bank at different words, a replay controller serves them over extra cycles. In each cycle and in each bank, the lowest-numbered lane still pending picks the word. Every pending lane that wants that same word is served alongside it. Identical-word accesses therefore share one cycle as a broadcast and never cost a replay. When no lane is left pending, the block pulses done and presents the read data of every lane. Requests enter through a valid/ready handshake that stays closed until the current request has fully drained.

Top module: `spad_top`

## Requirements
- R1: A lane's word address is its byte address shifted right by two, so byte-address bits [1:0] are ignored. The bank is the low log2(BANKS) bits of the word address, and the row inside the bank is the remaining upper bits.
- R2: A request whose enabled lanes all fall in different banks completes after exactly one service cycle.
- R3: The number of service cycles between acceptance and done equals the largest count of distinct word addresses that the enabled lanes place in any single bank. Done goes high on the sampling point after that many rising edges following the accepting edge.
- R4: Enabled lanes that name the same word address are served in the same cycle and add no service cycle.
- R5: When several enabled lanes of one write request target the same word, the word afterwards holds the data of the highest-numbered of those lanes. Lanes that are not enabled write nothing.
- R6: `inReady` is high when idle. It is low from the accepting edge until the cycle in which done is high. `inValid` presented while `inReady` is low has no effect on the memory or on the result.
- R7: `outDone` is high for exactly one cycle per request. `outRdata` then holds, per lane, the stored word for enabled lanes of a read request, and zero for disabled lanes and for every lane of a write request. It stays unchanged until the next request is accepted.
- R8: After reset, `inReady` is 1, `outDone` is 0 and `outRdata` is all zero.
- R9: A request with no lane enabled completes after one service cycle and returns all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block can accept a request |
| inWrite | input | 1 | 1 = write request, 0 = read request |
| inMask | input | LANES | Per-lane enable |
| inAddr | input | LANES*ADDR_W | Per-lane byte address, lane i at bits [i*ADDR_W +: ADDR_W] |
| inWdata | input | LANES*DW | Per-lane write data, lane i at bits [i*DW +: DW] |
| outDone | output | 1 | One-cycle completion pulse |
| outRdata | output | LANES*DW | Per-lane read result, lane i at bits [i*DW +: DW] |

## Verification
The bench builds the block with 8 lanes, 4 banks and 4 rows per bank, which gives a 16-word memory. At that size, every bank-to-lane distribution from fully spread to all eight lanes in one bank can be reached in a few hundred requests. Each word can be written and read back through a bench-side model. Directed cases cover pure broadcast, worst-case single-bank conflict, duplicate-word writes, empty masks and junk requests offered while busy. A long pseudo-random sweep of mixed reads and writes compares the latency and every lane's data with the arithmetic model.

// File: rtl/spad_pkg.sv
package spad_pkg;

  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic load;   // capture a new request this edge
    logic step;   // perform one service cycle this edge
  } spadCtl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } spadState_t;

endpackage

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     lastStep,
  output logic     inReady,
  output logic     outDone,
  output spadCtl_t ctl
);

  spadState_t state;

  assign inReady  = (state == ST_IDLE);
  assign ctl.load = inValid && (state == ST_IDLE);
  assign ctl.step = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      outDone <= 1'b0;
    end else begin
      outDone <= 1'b0;
      if (ctl.load) begin
        state <= ST_BUSY;
      end else if (state == ST_BUSY && lastStep) begin
        state   <= ST_IDLE;
        outDone <= 1'b1;
      end
    end
  end

  // R6: an accepted request closes the handshake on the next cycle
  a_r6_closed_after_accept : assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> !inReady);

  // R7: done lasts a single cycle
  a_r7_done_single_cycle : assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> !outDone);

  // R6: the handshake reopens together with done
  a_r6_ready_with_done : assert property (@(posedge clk) disable iff (!rstN)
    outDone |-> inReady);

endmodule

// File: rtl/spad_datapath.sv
module spad_datapath
  import spad_pkg::*;
#(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = $clog2(DEPTH),
  localparam int WAW  = BW + RW
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  spadCtl_t             ctl,
  input  logic                 inWrite,
  input  logic [LANES-1:0]     inMask,
  input  logic [LANES*WAW-1:0] inWord,
  input  logic [LANES*DW-1:0]  inWdata,
  output logic [LANES-1:0]     pending,
  output logic                 lastStep,
  output logic [LANES*DW-1:0]  outRdata
);

  logic             reqWrite;
  logic [WAW-1:0]   wordR    [LANES];
  logic [DW-1:0]    wdataR   [LANES];
  logic [DW-1:0]    rdataR   [LANES];
  logic [BW-1:0]    laneBank [LANES];
  logic [RW-1:0]    laneRow  [LANES];
  logic [DW-1:0]    laneRd   [LANES];
  logic [RW-1:0]    selRow   [BANKS];
  logic [DW-1:0]    bankRd   [BANKS];
  logic [LANES-1:0] served;

  // Lane address split: low bits pick the bank, upper bits the row
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      laneBank[i] = wordR[i][BW-1:0];
      laneRow[i]  = wordR[i][WAW-1:BW];
    end
  end

  // Per-bank storage, winner selection and write port
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic          found;

    // Lowest-numbered pending lane in this bank chooses the row
    always_comb begin
      found     = 1'b0;
      selRow[b] = '0;
      for (int i = 0; i < LANES; i++) begin
        if (!found && pending[i] && laneBank[i] == BW'(b)) begin
          found     = 1'b1;
          selRow[b] = laneRow[i];
        end
      end
    end

    assign bankRd[b] = mem[selRow[b]];

    // Ascending lane order: the highest served writer lands last
    always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
        if (ctl.step && reqWrite && served[i] && laneBank[i] == BW'(b))
          mem[selRow[b]] <= wdataR[i];
      end
    end
  end

  // A lane is served when its row matches its bank's chosen row
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      served[i] = pending[i] && (laneRow[i] == selRow[laneBank[i]]);
      laneRd[i] = bankRd[laneBank[i]];
    end
  end

  assign lastStep = ((pending & ~served) == '0);

  always_ff @(posedge clk) begin
    if (ctl.load) begin
      for (int i = 0; i < LANES; i++) begin
        wordR[i]  <= inWord[i*WAW +: WAW];
        wdataR[i] <= inWdata[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= '0;
      reqWrite <= 1'b0;
      for (int i = 0; i < LANES; i++) rdataR[i] <= '0;
    end else if (ctl.load) begin
      pending  <= inMask;
      reqWrite <= inWrite;
      for (int i = 0; i < LANES; i++) rdataR[i] <= '0;
    end else if (ctl.step) begin
      pending <= pending & ~served;
      for (int i = 0; i < LANES; i++) begin
        if (served[i] && !reqWrite) rdataR[i] <= laneRd[i];
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign outRdata[i*DW +: DW] = rdataR[i];
  end

  // R3: service never adds pending lanes back
  a_r3_pending_never_grows : assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (pending & ~$past(pending)) == '0);

  // R3: each service cycle retires at least one lane
  a_r3_progress : assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && pending != '0) |=> $countones(pending) < $countones($past(pending)));

  // R9: an empty request finishes in its first service cycle
  a_r9_empty_done : assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && inMask == '0) |=> lastStep);

endmodule

// File: rtl/spad_top.sv
module spad_top
  import spad_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int DEPTH  = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = $clog2(BANKS) + $clog2(DEPTH) + 2
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic                    inWrite,
  input  logic [LANES-1:0]        inMask,
  input  logic [LANES*ADDR_W-1:0] inAddr,
  input  logic [LANES*DW-1:0]     inWdata,
  output logic                    outDone,
  output logic [LANES*DW-1:0]     outRdata
);

  localparam int WAW = $clog2(BANKS) + $clog2(DEPTH);

  spadCtl_t             ctl;
  logic [LANES-1:0]     pending;
  logic                 lastStep;
  logic [LANES*WAW-1:0] laneWord;
  logic [2*LANES-1:0]   unusedLowBits;

  // Drop the byte offset: only word addresses reach the banks
  for (genvar i = 0; i < LANES; i++) begin : g_word
    assign laneWord[i*WAW +: WAW]    = inAddr[i*ADDR_W + 2 +: WAW];
    assign unusedLowBits[2*i +: 2]   = inAddr[i*ADDR_W +: 2];
  end

  spad_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .lastStep (lastStep),
    .inReady  (inReady),
    .outDone  (outDone),
    .ctl      (ctl)
  );

  spad_datapath #(
    .LANES (LANES),
    .BANKS (BANKS),
    .DEPTH (DEPTH),
    .DW    (DW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inWrite  (inWrite),
    .inMask   (inMask),
    .inWord   (laneWord),
    .inWdata  (inWdata),
    .pending  (pending),
    .lastStep (lastStep),
    .outRdata (outRdata)
  );

  // R7: done is only reported once no lane is left pending
  a_r7_done_drained : assert property (@(posedge clk) disable iff (!rstN)
    outDone |-> pending == '0);

endmodule

// File: tb/spad_top_bench.sv
module spad_top_bench;

  localparam int LANES = 8;
  localparam int BANKS = 4;
  localparam int DEPTH = 4;
  localparam int DW    = 32;
  localparam int AW    = 6;
  localparam int WORDS = BANKS * DEPTH;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic                 inReady;
  logic                 inWrite = 1'b0;
  logic [LANES-1:0]     inMask = '0;
  logic [LANES*AW-1:0]  inAddr = '0;
  logic [LANES*DW-1:0]  inWdata = '0;
  logic                 outDone;
  logic [LANES*DW-1:0]  outRdata;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;
  bit finished = 1'b0;

  // Bench-side request description and memory model
  logic            reqWr;
  logic [LANES-1:0] reqMask;
  int              reqWord [LANES];
  logic [1:0]      reqLow  [LANES];
  logic [DW-1:0]   reqData [LANES];
  logic [DW-1:0]   model   [WORDS];
  logic [31:0]     seed = 32'h1234_5678;

  always #5 clk = ~clk;

  spad_top #(
    .LANES (LANES), .BANKS (BANKS), .DEPTH (DEPTH), .DW (DW), .ADDR_W (AW)
  ) u_spad_top (
    .clk (clk), .rstN (rstN), .inValid (inValid), .inReady (inReady),
    .inWrite (inWrite), .inMask (inMask), .inAddr (inAddr), .inWdata (inWdata),
    .outDone (outDone), .outRdata (outRdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // Drive one request, check latency, handshake and per-lane data
  task automatic runReq(input string req, input bit junk);
    int perBank [BANKS];
    int expCyc;
    int cnt;
    bit dup;
    logic [DW-1:0] expRd [LANES];
    for (int b = 0; b < BANKS; b++) perBank[b] = 0;
    for (int i = 0; i < LANES; i++) begin
      if (reqMask[i]) begin
        dup = 1'b0;
        for (int j = 0; j < i; j++)
          if (reqMask[j] && reqWord[j] == reqWord[i]) dup = 1'b1;
        if (!dup) perBank[reqWord[i] % BANKS]++;
      end
    end
    expCyc = 1;
    for (int b = 0; b < BANKS; b++) if (perBank[b] > expCyc) expCyc = perBank[b];
    for (int i = 0; i < LANES; i++)
      expRd[i] = (reqMask[i] && !reqWr) ? model[reqWord[i]] : '0;
    if (reqWr)
      for (int i = 0; i < LANES; i++) if (reqMask[i]) model[reqWord[i]] = reqData[i];

    @(negedge clk);
    chk(inReady === 1'b1, "R6", "ready idle", inReady, 1);
    inWrite = reqWr;
    inMask  = reqMask;
    for (int i = 0; i < LANES; i++) begin
      inAddr[i*AW +: AW] = {4'(reqWord[i]), reqLow[i]};
      inWdata[i*DW +: DW] = reqData[i];
    end
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk(inReady === 1'b0, "R6", "ready busy", inReady, 0);
    cnt = 0;
    if (junk) begin
      // Offer a full-mask write while busy: must be ignored
      inWrite = 1'b1;
      inMask  = '1;
      for (int i = 0; i < LANES; i++) begin
        inAddr[i*AW +: AW] = AW'(i * 2);
        inWdata[i*DW +: DW] = 32'hDEAD_0000 + i;
      end
      inValid = 1'b1;
      @(posedge clk);
      cnt++;
      @(negedge clk);
      inValid = 1'b0;
    end
    while (!outDone && cnt < 64) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    chk(cnt == expCyc, req, "service cycles", cnt, expCyc);
    chk(inReady === 1'b1, "R6", "ready at done", inReady, 1);
    for (int i = 0; i < LANES; i++)
      chk(outRdata[i*DW +: DW] === expRd[i], (reqWr || !reqMask[i]) ? "R7" : req,
          $sformatf("lane %0d data", i), outRdata[i*DW +: DW], expRd[i]);
    @(posedge clk);
    @(negedge clk);
    chk(outDone === 1'b0, "R7", "done one cycle", outDone, 0);
    chk(outRdata[0 +: DW] === expRd[0], "R7", "data held", outRdata[0 +: DW], expRd[0]);
  endtask

  task automatic clearReq();
    reqWr = 1'b0;
    reqMask = '0;
    for (int i = 0; i < LANES; i++) begin
      reqWord[i] = 0;
      reqLow[i]  = 2'b00;
      reqData[i] = '0;
    end
  endtask

  // Read back every word, two lanes per word position sweep
  task automatic readAll();
    for (int base = 0; base < WORDS; base += LANES) begin
      clearReq();
      reqMask = '1;
      for (int i = 0; i < LANES; i++) reqWord[i] = base + i;
      runReq("R3", 1'b0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > 150000 && !finished) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycleCount);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    for (int w = 0; w < WORDS; w++) model[w] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk(inReady === 1'b1, "R8", "ready after reset", inReady, 1);
    chk(outDone === 1'b0, "R8", "done after reset", outDone, 0);
    chk(outRdata === '0, "R8", "rdata after reset", outRdata[31:0], 0);
    rstN = 1'b1;

    // Fill all words: each bank sees two distinct rows -> two cycles (R3)
    for (int base = 0; base < WORDS; base += LANES) begin
      clearReq();
      reqWr = 1'b1;
      reqMask = '1;
      for (int i = 0; i < LANES; i++) begin
        reqWord[i] = base + i;
        reqData[i] = 32'hA500_0000 + (base + i) * 32'h0101;
      end
      runReq("R3", 1'b0);
    end
    readAll();

    // R2: distinct banks, one cycle
    clearReq();
    reqMask = 8'h0F;
    for (int i = 0; i < 4; i++) reqWord[i] = 8 + ((i + 1) % 4);
    runReq("R2", 1'b0);

    // R4: all lanes same word, broadcast in one cycle
    clearReq();
    reqMask = '1;
    for (int i = 0; i < LANES; i++) reqWord[i] = 5;
    runReq("R4", 1'b0);

    // R4: two words per bank-pair pattern with duplicates, mixed
    clearReq();
    reqMask = '1;
    for (int i = 0; i < LANES; i++) reqWord[i] = (i % 2) ? 6 : 3;
    runReq("R4", 1'b0);

    // R3: worst case, all lanes in bank 0 over four rows
    clearReq();
    reqMask = '1;
    for (int i = 0; i < LANES; i++) reqWord[i] = (i % 4) * 4;
    runReq("R3", 1'b0);

    // R1: byte offset bits ignored
    clearReq();
    reqMask = '1;
    for (int i = 0; i < LANES; i++) begin
      reqWord[i] = 7 + i;
      reqLow[i]  = 2'(i + 1);
    end
    runReq("R1", 1'b0);

    // R5: several lanes write word 9, lane 7 disabled
    clearReq();
    reqWr = 1'b1;
    reqMask = 8'h7D;
    for (int i = 0; i < LANES; i++) begin
      reqWord[i] = 9;
      reqData[i] = 32'h5500_0000 + i;
    end
    runReq("R5", 1'b0);
    clearReq();
    reqMask = 8'h01;
    reqWord[0] = 9;
    runReq("R5", 1'b0);
    chk(model[9] == 32'h5500_0006, "R5", "model winner lane", model[9], 32'h5500_0006);

    // R9: empty mask
    clearReq();
    runReq("R9", 1'b0);

    // R6: request offered while busy is ignored
    clearReq();
    reqMask = '1;
    for (int i = 0; i < LANES; i++) reqWord[i] = (i % 4) * 4 + 1;
    runReq("R6", 1'b1);
    readAll();

    // Pseudo-random sweep of reads and writes against the model
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      clearReq();
      r = nextRand();
      reqWr   = r[3];
      reqMask = r[15:8];
      for (int i = 0; i < LANES; i++) begin
        r = nextRand();
        reqWord[i] = (r[20]) ? int'(r[19:18]) * 4 : int'(r[19:16]);
        reqLow[i]  = r[25:24];
        reqData[i] = nextRand();
      end
      runReq("R3", 1'b0);
    end
    readAll();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule